// File: doc/BRIEF.md
# LCD Window and Pixel Stream Writer

This block turns a rectangular window request into the byte stream that a serial-command display controller with on-chip graphics RAM expects. It sends the window's column range and row range, opens a memory write, and then repacks incoming blue-green-red byte triples into 16-bit RGB565 colours. Each colour leaves as two bytes. Every output byte carries a data/command flag, and bytes leave through a valid/ready handshake. The serial shifter, image source and controller bring-up sit outside the block.

The control is a five-state machine:
- **IDLE**: waits for a start pulse.
- **HDR**: emits the 11 header bytes.
- **GATHER**: accepts three source bytes.
- **HI**: sends the colour's upper byte.
- **LO**: sends the colour's lower byte.

The transitions are:
- **IDLE→HDR** on a valid start.
- **IDLE→IDLE** with an error pulse on a bad window.
- **HDR→GATHER** after the eleventh byte is accepted.
- **GATHER→HI** when the third byte of a pixel is taken.
- **HI→LO** when the upper byte is accepted.
- **LO→GATHER** when more pixels remain.
- **LO→IDLE** with a done pulse after the last pixel.

Top module: `lcd_win_writer`

## Requirements
- R1: After reset, out_valid_o, pix_ready_o, done_o and err_o are all low.
- R2: A start emits, in this order: command 0x2A, x0 high byte, x0 low byte, x1 high byte, x1 low byte; command 0x2B, y0 high, y0 low, y1 high, y1 low; command 0x2C.
- R3: out_dc_o is 0 for the three command bytes (0x2A, 0x2B, 0x2C) and 1 for every coordinate and pixel byte.
- R4: Source bytes for one pixel arrive as blue, then green, then red. The colour is {red[7:3], green[7:2], blue[7:3]}, with red in bits 15:11, green in 10:5 and blue in 4:0.
- R5: Each colour is sent as bits 15:8 first, then bits 7:0.
- R6: Exactly (x1-x0+1)*(y1-y0+1) pixels are taken. A one-cycle done_o pulse follows the last pixel's low byte, and the block is idle again afterwards.
- R7: pix_ready_o is low while any header byte is pending, while a colour byte is pending, and whenever out_ready_i is low.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_byte_o and out_dc_o hold their values into the next cycle.
- R9: A start pulse while a window is in progress has no effect on the stream.
- R10: A start with x1<x0 or y1<y0 gives a one-cycle err_o pulse, emits no byte and gives no done_o.
- R11: A full-screen window (0,0)-(239,319) produces the coordinate bytes 00 00 00 EF and 00 00 01 3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Window request pulse |
| win_x0_i | input | 16 | First column |
| win_y0_i | input | 16 | First row |
| win_x1_i | input | 16 | Last column |
| win_y1_i | input | 16 | Last row |
| pix_valid_i | input | 1 | Source byte valid |
| pix_byte_i | input | 8 | Source byte (blue, green, red order) |
| pix_ready_o | output | 1 | Source byte accepted this cycle when high with valid |
| out_valid_o | output | 1 | Output byte valid |
| out_byte_o | output | 8 | Output byte |
| out_dc_o | output | 1 | 0 = command byte, 1 = data byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle pulse after the final pixel |
| err_o | output | 1 | One-cycle pulse on a rejected window |

## Verification
The windows tried are:
- A 2x2 window with small coordinates.
- A 1x3 window whose coordinates cross a byte boundary.
- The full screen.

Together they separate correct high/low byte splitting and the column-before-row order from swapped or truncated coordinates.

The pixel values are chosen to tell the colour packing apart from wrong variants:
- Pure blue, green and red light each field alone.
- A mixed value tells the channels apart.
- Values just under and on a truncation step expose an off-by-one in the bit slicing.

The same stream is run again under periodic backpressure to expose stalls that drop or alter bytes. Inverted windows and a second start mid-window check that rejected or ignored requests leave the output silent.

// File: rtl/lcd_win_pkg.sv
package lcd_win_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_GATHER,
        ST_HI,
        ST_LO
    } wr_state_t;

    localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
    localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
    localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
    localparam int unsigned HDR_LEN      = 11;
endpackage

// File: rtl/lcd_px_pack.sv
module lcd_px_pack #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              complete_o,
    output logic [15:0]       color_o
);
    logic [1:0]        idx_q;
    logic [BYTE_W-1:0] blu_q;
    logic [BYTE_W-1:0] grn_q;

    assign complete_o = take && (idx_q == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            blu_q   <= '0;
            grn_q   <= '0;
            color_o <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (take) begin
            unique case (idx_q)
                2'd0: begin
                    blu_q <= byte_i;
                    idx_q <= 2'd1;
                end
                2'd1: begin
                    grn_q <= byte_i;
                    idx_q <= 2'd2;
                end
                default: begin
                    color_o <= {byte_i[BYTE_W-1 -: 5], grn_q[BYTE_W-1 -: 6], blu_q[BYTE_W-1 -: 5]};
                    idx_q   <= 2'd0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lcd_px_count.sv
module lcd_px_count #(
    parameter int unsigned COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [COORD_W-1:0] col_last,
    input  logic [COORD_W-1:0] row_last,
    output logic               last_o
);
    logic [COORD_W-1:0] col_q;
    logic [COORD_W-1:0] row_q;
    logic               col_end;

    assign col_end = (col_q == col_last);
    assign last_o  = col_end && (row_q == row_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (clr) begin
            col_q <= '0;
            row_q <= '0;
        end else if (step) begin
            if (col_end) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_win_writer.sv
module lcd_win_writer
    import lcd_win_pkg::*;
#(
    parameter int unsigned COORD_W = 16,
    parameter int unsigned BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [COORD_W-1:0] win_x0_i,
    input  logic [COORD_W-1:0] win_y0_i,
    input  logic [COORD_W-1:0] win_x1_i,
    input  logic [COORD_W-1:0] win_y1_i,
    input  logic               pix_valid_i,
    input  logic [BYTE_W-1:0]  pix_byte_i,
    output logic               pix_ready_o,
    output logic               out_valid_o,
    output logic [BYTE_W-1:0]  out_byte_o,
    output logic               out_dc_o,
    input  logic               out_ready_i,
    output logic               done_o,
    output logic               err_o
);
    localparam int unsigned IDX_W = $clog2(HDR_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

    wr_state_t          state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [COORD_W-1:0] x0_q, y0_q, x1_q, y1_q;
    logic [15:0]        x0_w, y0_w, x1_w, y1_w;
    logic               win_ok, accept, take, pix_done, px_last, step, xfer;
    logic [15:0]        color;
    logic [BYTE_W-1:0]  hdr_byte;
    logic               hdr_cmd;

    assign win_ok = (win_x1_i >= win_x0_i) && (win_y1_i >= win_y0_i);
    assign accept = (state_q == ST_IDLE) && start_i && win_ok;
    assign take   = pix_valid_i && pix_ready_o;
    assign xfer   = out_valid_o && out_ready_i;
    assign step   = (state_q == ST_LO) && out_ready_i;

    assign x0_w = 16'(x0_q);
    assign y0_w = 16'(y0_q);
    assign x1_w = 16'(x1_q);
    assign y1_w = 16'(y1_q);

    lcd_px_pack #(.BYTE_W(BYTE_W)) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (accept),
        .take       (take),
        .byte_i     (pix_byte_i),
        .complete_o (pix_done),
        .color_o    (color)
    );

    lcd_px_count #(.COORD_W(COORD_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .step     (step),
        .col_last (x1_q - x0_q),
        .row_last (y1_q - y0_q),
        .last_o   (px_last)
    );

    // header byte selection by position in the header
    always_comb begin
        hdr_cmd  = 1'b0;
        hdr_byte = '0;
        unique case (idx_q)
            4'd0:    begin hdr_byte = CMD_COL_RANGE; hdr_cmd = 1'b1; end
            4'd1:    hdr_byte = x0_w[15:8];
            4'd2:    hdr_byte = x0_w[7:0];
            4'd3:    hdr_byte = x1_w[15:8];
            4'd4:    hdr_byte = x1_w[7:0];
            4'd5:    begin hdr_byte = CMD_ROW_RANGE; hdr_cmd = 1'b1; end
            4'd6:    hdr_byte = y0_w[15:8];
            4'd7:    hdr_byte = y0_w[7:0];
            4'd8:    hdr_byte = y1_w[15:8];
            4'd9:    hdr_byte = y1_w[7:0];
            4'd10:   begin hdr_byte = CMD_MEM_WRITE; hdr_cmd = 1'b1; end
            default: hdr_byte = '0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_HDR;
            ST_HDR:    if (out_ready_i && idx_q == IDX_LAST) state_d = ST_GATHER;
            ST_GATHER: if (pix_done) state_d = ST_HI;
            ST_HI:     if (out_ready_i) state_d = ST_LO;
            ST_LO:     if (out_ready_i) state_d = px_last ? ST_IDLE : ST_GATHER;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            x0_q    <= '0;
            y0_q    <= '0;
            x1_q    <= '0;
            y1_q    <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= step && px_last;
            err_o   <= (state_q == ST_IDLE) && start_i && !win_ok;
            if (accept) begin
                idx_q <= '0;
                x0_q  <= win_x0_i;
                y0_q  <= win_y0_i;
                x1_q  <= win_x1_i;
                y1_q  <= win_y1_i;
            end else if (state_q == ST_HDR && xfer) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid_o = 1'b0;
        out_byte_o  = '0;
        out_dc_o    = 1'b1;
        pix_ready_o = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                out_valid_o = 1'b1;
                out_byte_o  = hdr_byte;
                out_dc_o    = !hdr_cmd;
            end
            ST_GATHER: pix_ready_o = out_ready_i;
            ST_HI: begin
                out_valid_o = 1'b1;
                out_byte_o  = color[15:8];
            end
            ST_LO: begin
                out_valid_o = 1'b1;
                out_byte_o  = color[7:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lcd_win_writer_chk.sv
module lcd_win_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic [7:0] out_byte_o,
    input logic       out_dc_o,
    input logic       pix_ready_o,
    input logic       done_o,
    input logic       err_o
);
    // R3
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_dc_o) |-> (out_byte_o == 8'h2A || out_byte_o == 8'h2B || out_byte_o == 8'h2C));

    // R7
    pix_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |-> (out_ready_i && !out_valid_o));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_byte_o) && $stable(out_dc_o)));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!out_valid_o && !done_o));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!out_valid_o && !pix_ready_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind lcd_win_writer lcd_win_writer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_byte_o  (out_byte_o),
    .out_dc_o    (out_dc_o),
    .pix_ready_o (pix_ready_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/lcd_win_writer_tb_top.sv
module lcd_win_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] win_x0_i = '0, win_y0_i = '0, win_x1_i = '0, win_y1_i = '0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_byte_i = '0;
    logic        pix_ready_o, out_valid_o, out_dc_o, done_o, err_o;
    logic [7:0]  out_byte_o;
    logic        out_ready_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit bp_on = 1'b0;

    logic [7:0] cap_b [0:2047];
    logic       cap_dc [0:2047];
    int cap_n = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int r7_bad = 0;
    int r8_bad = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_b = '0;
    logic prev_dc = 1'b0;

    always #10 clk = ~clk;

    lcd_win_writer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .win_x0_i(win_x0_i), .win_y0_i(win_y0_i), .win_x1_i(win_x1_i), .win_y1_i(win_y1_i),
        .pix_valid_i(pix_valid_i), .pix_byte_i(pix_byte_i), .pix_ready_o(pix_ready_o),
        .out_valid_o(out_valid_o), .out_byte_o(out_byte_o), .out_dc_o(out_dc_o),
        .out_ready_i(out_ready_i), .done_o(done_o), .err_o(err_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 out_ready_i = bp_on ? ((cyc % 3) != 2) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o && out_ready_i) begin
                cap_b[cap_n]  = out_byte_o;
                cap_dc[cap_n] = out_dc_o;
                cap_n++;
            end
            if (done_o) done_cnt++;
            if (err_o) err_cnt++;
            if (pix_ready_o && (!out_ready_i || out_valid_o)) r7_bad++;
            if (prev_stall && (!out_valid_o || out_byte_o != prev_b || out_dc_o != prev_dc)) r8_bad++;
            prev_stall = out_valid_o && !out_ready_i;
            prev_b     = out_byte_o;
            prev_dc    = out_dc_o;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rgb565(logic [7:0] b, logic [7:0] g, logic [7:0] r);
        return {r[7:3], g[7:2], b[7:3]};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start(logic [15:0] x0, logic [15:0] y0, logic [15:0] x1, logic [15:0] y1);
        @(posedge clk); #2;
        win_x0_i = x0; win_y0_i = y0; win_x1_i = x1; win_y1_i = y1;
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic wait_bytes(int n);
        int t = 0;
        while (cap_n < n && t < 2000) begin
            @(posedge clk);
            t++;
        end
        #2;
    endtask

    task automatic send_byte(logic [7:0] b);
        pix_valid_i = 1'b1;
        pix_byte_i  = b;
        do @(negedge clk); while (!pix_ready_o);
        @(posedge clk); #2;
        pix_valid_i = 1'b0;
    endtask

    task automatic send_pixel(logic [7:0] b, logic [7:0] g, logic [7:0] r);
        send_byte(b);
        send_byte(g);
        send_byte(r);
    endtask

    task automatic chk_hdr(int base, logic [15:0] x0, logic [15:0] y0, logic [15:0] x1, logic [15:0] y1, string tag);
        logic [7:0] e [0:10];
        e = '{8'h2A, x0[15:8], x0[7:0], x1[15:8], x1[7:0],
              8'h2B, y0[15:8], y0[7:0], y1[15:8], y1[7:0], 8'h2C};
        for (int i = 0; i < 11; i++) begin
            check(cap_b[base+i] === e[i], tag, int'(cap_b[base+i]), int'(e[i]));
            // R3: command positions 0, 5, 10 carry dc 0
            check(cap_dc[base+i] === ((i == 0 || i == 5 || i == 10) ? 1'b0 : 1'b1),
                  "R3 dc flag", int'(cap_dc[base+i]), (i == 0 || i == 5 || i == 10) ? 0 : 1);
        end
    endtask

    task automatic chk_pix(int base, int k, logic [15:0] col);
        // R5 high byte first, R4 packing
        check(cap_b[base+11+2*k] === col[15:8], "R4 R5 high byte", int'(cap_b[base+11+2*k]), int'(col[15:8]));
        check(cap_b[base+12+2*k] === col[7:0], "R4 R5 low byte", int'(cap_b[base+12+2*k]), int'(col[7:0]));
        check(cap_dc[base+11+2*k] === 1'b1 && cap_dc[base+12+2*k] === 1'b1, "R3 pixel dc", 0, 1);
    endtask

    task automatic test_reset;
        // R1
        check(out_valid_o === 1'b0, "R1 out_valid", int'(out_valid_o), 0);
        check(pix_ready_o === 1'b0, "R1 pix_ready", int'(pix_ready_o), 0);
        check(done_o === 1'b0 && err_o === 1'b0, "R1 pulses", int'({done_o, err_o}), 0);
    endtask

    task automatic test_small;
        int base = cap_n;
        int d0 = done_cnt;
        logic [7:0] pb [0:3] = '{8'hFF, 8'h00, 8'h00, 8'h12};
        logic [7:0] pg [0:3] = '{8'h00, 8'hFF, 8'h00, 8'h34};
        logic [7:0] pr [0:3] = '{8'h00, 8'h00, 8'hFF, 8'h56};
        pulse_start(16'd1, 16'd2, 16'd2, 16'd3);
        wait_bytes(base + 11);
        chk_hdr(base, 16'd1, 16'd2, 16'd2, 16'd3, "R2 header small");
        for (int i = 0; i < 4; i++) begin
            send_pixel(pb[i], pg[i], pr[i]);
            if (i == 2) begin
                tick(6);
                // R6: no done before last pixel
                check(done_cnt == d0, "R6 early done", done_cnt - d0, 0);
            end
        end
        wait_bytes(base + 19);
        tick(4);
        for (int i = 0; i < 4; i++) chk_pix(base, i, rgb565(pb[i], pg[i], pr[i]));
        check(done_cnt == d0 + 1, "R6 done count", done_cnt - d0, 1);
        check(cap_n == base + 19, "R6 byte total", cap_n - base, 19);
    endtask

    task automatic test_backpressure;
        int base;
        int d0 = done_cnt;
        logic [7:0] pb [0:2] = '{8'h07, 8'h08, 8'hF8};
        logic [7:0] pg [0:2] = '{8'h03, 8'h04, 8'hFC};
        logic [7:0] pr [0:2] = '{8'h07, 8'h08, 8'hF8};
        bp_on = 1'b1;
        base = cap_n;
        pulse_start(16'h0102, 16'h00FF, 16'h0102, 16'h0101);
        wait_bytes(base + 11);
        chk_hdr(base, 16'h0102, 16'h00FF, 16'h0102, 16'h0101, "R2 header wide");
        for (int i = 0; i < 3; i++) send_pixel(pb[i], pg[i], pr[i]);
        wait_bytes(base + 17);
        tick(6);
        bp_on = 1'b0;
        for (int i = 0; i < 3; i++) chk_pix(base, i, rgb565(pb[i], pg[i], pr[i]));
        check(done_cnt == d0 + 1, "R6 done under stall", done_cnt - d0, 1);
        check(r7_bad == 0, "R7 pix ready gating", r7_bad, 0);
        check(r8_bad == 0, "R8 stall hold", r8_bad, 0);
    endtask

    task automatic test_busy;
        int base = cap_n;
        int d0 = done_cnt;
        pulse_start(16'd0, 16'd0, 16'd1, 16'd0);
        tick(2);
        // R9: second start mid-header
        pulse_start(16'd5, 16'd5, 16'd9, 16'd9);
        wait_bytes(base + 11);
        chk_hdr(base, 16'd0, 16'd0, 16'd1, 16'd0, "R9 header kept");
        send_pixel(8'h10, 8'h20, 8'h30);
        send_pixel(8'h40, 8'h50, 8'h60);
        tick(8);
        check(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
        check(cap_n == base + 15, "R9 byte total", cap_n - base, 15);
        check(pix_ready_o === 1'b0 && out_valid_o === 1'b0, "R6 idle after done",
              int'({pix_ready_o, out_valid_o}), 0);
    endtask

    task automatic test_reject;
        int base = cap_n;
        int e0 = err_cnt;
        int d0 = done_cnt;
        pulse_start(16'd10, 16'd0, 16'd9, 16'd0);
        tick(5);
        check(err_cnt == e0 + 1, "R10 err x", err_cnt - e0, 1);
        pulse_start(16'd0, 16'd7, 16'd3, 16'd6);
        tick(5);
        check(err_cnt == e0 + 2, "R10 err y", err_cnt - e0, 2);
        check(cap_n == base, "R10 no bytes", cap_n - base, 0);
        check(done_cnt == d0, "R10 no done", done_cnt - d0, 0);
    endtask

    task automatic test_full;
        int base = cap_n;
        pulse_start(16'd0, 16'd0, 16'd239, 16'd319);
        wait_bytes(base + 11);
        // R11
        chk_hdr(base, 16'd0, 16'd0, 16'd239, 16'd319, "R11 full screen");
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        tick(3);
        test_reset();
        rst_n = 1'b1;
        tick(2);
        test_reset();
        test_small();
        test_backpressure();
        test_busy();
        test_reject();
        test_full();
        finish_run();
    end
endmodule